// File: doc/BRIEF.md
# ATM Cell Receive Port

This block is the receive side of an 8-bit cell port. A sender pushes 53-byte ATM cells into it one byte per clock while a write enable is high. The first byte of every cell carries a start-of-cell strobe. Cells go into a small store that is managed in whole-cell slots. A cell becomes visible on the read side only after its last byte has arrived. A cell-available flag tells the sender whether one more complete cell would fit.

A cell that is cut short by a new start-of-cell is thrown away. The new strobe starts the next cell at once. A port enable is sampled only at a start-of-cell, so disabling the port never truncates a cell that is already under way. In an optional addressed (multi-PHY) mode, the flag is driven only in the cycle after the port's own address is seen on a shared poll bus. The read side is a byte stream with valid/ready handshaking and a first-byte marker.

Top module: `cell_rx_port`

## Requirements
- R1: A cell is exactly CELL_BYTES (53) bytes. A byte is taken on a rising clock edge when `wr_en` is 1. The byte with `soc`=1 is byte 0 of a cell. While `wr_en` is 0 the transfer pauses, and the cell in progress is kept.
- R2: The store holds CELL_SLOTS (4) complete cells. A start-of-cell that arrives while all slots hold unread cells is ignored, together with the rest of that cell. A cell reaches the read side only after all 53 of its bytes have been taken.
- R3: `clav` is 1 when the number of stored unread cells plus any cell in progress is below CELL_SLOTS. It already reflects a byte in the cycle that follows the edge that accepted that byte. This means it drops right after the first byte of the cell that takes the last free slot.
- R4: The read side shows `rd_valid` while a complete cell is stored. It delivers the bytes in arrival order, one byte for each edge where `rd_valid` and `rd_ready` are both 1. `rd_first` is 1 on byte 0 of each cell. A slot is released only when its 53rd byte is read.
- R5: Clearing `port_en` during a cell lets that cell finish and be stored. Later cells are ignored while `port_en` is 0.
- R6: A start-of-cell that arrives before the current cell is complete discards the partial cell entirely. The new strobe begins a new cell.
- R7: With `mphy_mode`=1, `clav_oe` is 1 only in the cycle after `poll_addr` equalled PORT_ADDR. When `clav_oe` is 0, `clav` is 0. With `mphy_mode`=0, `clav_oe` is 1 from the first edge after reset.
- R8: Bytes with `soc`=0 that arrive while no cell is in progress are ignored.
- R9: A start-of-cell that arrives while `port_en` is 0 and the port is idle is ignored. After `port_en` returns to 1, reception resumes at the next start-of-cell.
- R10: While `rst` is 1, `rd_valid`, `clav` and `clav_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Receive enable, sampled at start-of-cell |
| mphy_mode | input | 1 | Addressed multi-PHY mode for the flag |
| poll_addr | input | ADDR_W | Shared poll address bus |
| wr_en | input | 1 | Byte-valid strobe from the sender |
| soc | input | 1 | Start-of-cell strobe |
| din | input | DATA_W | Incoming byte |
| clav | output | 1 | Room for one more complete cell |
| clav_oe | output | 1 | Output enable for `clav` |
| rd_data | output | DATA_W | Byte at the head of the store |
| rd_valid | output | 1 | A stored byte is available |
| rd_ready | input | 1 | Reader accepts the byte |
| rd_first | output | 1 | Head byte is byte 0 of a cell |

## Verification
The assertions assume a reader that holds a byte until it is accepted. They also assume the port itself never commits a cell into a full store; that limit holds only because a start-of-cell is refused when no slot is free. The assertions do not constrain the sender's behaviour with respect to `clav`. The stimulus therefore deliberately sends a cell while the store is full, sends stray bytes, and truncates cells, so that every refusal path is exercised. The reader handshake stays legal throughout: `rd_ready` changes only just after a clock edge.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;
  typedef enum logic {FR_IDLE, FR_BUSY} fr_state_t;
endpackage

// File: rtl/cell_rx_framer.sv
module cell_rx_framer
  import cell_rx_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int OFF_W      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             soc,
  input  logic             port_en,
  input  logic             space_ok,
  output logic             wr_strobe,
  output logic [OFF_W-1:0] wr_off,
  output logic             commit,
  output logic             busy,
  output logic             busy_nxt
);
  fr_state_t        st, st_n;
  logic [OFF_W-1:0] off, off_n;
  logic             start, cont, abort_c;

  always_comb begin
    start   = wr_en && soc && port_en && space_ok;
    cont    = wr_en && !soc && (st == FR_BUSY);
    abort_c = wr_en && soc && (st == FR_BUSY);
    commit  = cont && (off == OFF_W'(CELL_BYTES - 1));
    wr_strobe = start || cont;
    wr_off  = start ? '0 : off;
    st_n    = st;
    off_n   = off;
    if (start) begin
      st_n  = FR_BUSY;
      off_n = OFF_W'(1);
    end else if (cont) begin
      if (commit) begin
        st_n  = FR_IDLE;
        off_n = '0;
      end else begin
        off_n = off + OFF_W'(1);
      end
    end else if (abort_c) begin
      st_n  = FR_IDLE;
      off_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= FR_IDLE;
      off <= '0;
    end else begin
      st  <= st_n;
      off <= off_n;
    end
  end

  assign busy     = (st == FR_BUSY);
  assign busy_nxt = (st_n == FR_BUSY);

  // R9
  idle_soc_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && soc && !port_en) |=> !busy);

  // R6
  restart_rollback_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && soc) |=> (off <= OFF_W'(1)));

  // R8
  stray_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && !soc) |=> !busy);
endmodule

// File: rtl/cell_rx_store.sv
module cell_rx_store #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int CELL_SLOTS = 4,
  parameter int OFF_W      = 6,
  parameter int SLOT_W     = 2,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_strobe,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] din,
  input  logic              commit,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_first,
  output logic [CNT_W-1:0]  stored,
  output logic [CNT_W-1:0]  stored_nxt
);
  localparam int DEPTH = CELL_SLOTS * CELL_BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [SLOT_W-1:0] wslot, rslot;
  logic [OFF_W-1:0]  roff;
  logic [AW-1:0]     waddr, raddr;
  logic              fire, release_c;

  always_comb begin
    waddr     = AW'(int'(wslot) * CELL_BYTES + int'(wr_off));
    raddr     = AW'(int'(rslot) * CELL_BYTES + int'(roff));
    rd_valid  = (stored != '0);
    fire      = rd_valid && rd_ready;
    release_c = fire && (roff == OFF_W'(CELL_BYTES - 1));
    stored_nxt = stored + CNT_W'(commit) - CNT_W'(release_c);
  end

  always_ff @(posedge clk) begin
    if (wr_strobe) mem[waddr] <= din;
  end

  assign rd_data  = mem[raddr];
  assign rd_first = (roff == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wslot  <= '0;
      rslot  <= '0;
      roff   <= '0;
      stored <= '0;
    end else begin
      stored <= stored_nxt;
      if (commit)
        wslot <= (wslot == SLOT_W'(CELL_SLOTS - 1)) ? '0 : wslot + SLOT_W'(1);
      if (release_c) begin
        roff  <= '0;
        rslot <= (rslot == SLOT_W'(CELL_SLOTS - 1)) ? '0 : rslot + SLOT_W'(1);
      end else if (fire) begin
        roff <= roff + OFF_W'(1);
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> (stored < CNT_W'(CELL_SLOTS)));

  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_first)));
endmodule

// File: rtl/cell_rx_clav.sv
module cell_rx_clav #(
  parameter int CELL_SLOTS = 4,
  parameter int CNT_W      = 3,
  parameter int ADDR_W     = 5,
  parameter int PORT_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mphy_mode,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [CNT_W-1:0]  stored_nxt,
  input  logic              busy_nxt,
  output logic              clav,
  output logic              clav_oe
);
  logic room_n, oe_n;

  always_comb begin
    room_n = ({1'b0, stored_nxt} + (CNT_W + 1)'(busy_nxt)) < (CNT_W + 1)'(CELL_SLOTS);
    oe_n   = !mphy_mode || (poll_addr == ADDR_W'(PORT_ADDR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clav    <= 1'b0;
      clav_oe <= 1'b0;
    end else begin
      clav    <= room_n && oe_n;
      clav_oe <= oe_n;
    end
  end

  // R7
  addr_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (mphy_mode && poll_addr != ADDR_W'(PORT_ADDR)) |=> !clav_oe);

  // R7
  clav_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !clav_oe |-> !clav);
endmodule

// File: rtl/cell_rx_port.sv
module cell_rx_port #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int CELL_SLOTS = 4,
  parameter int ADDR_W     = 5,
  parameter int PORT_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              mphy_mode,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic              wr_en,
  input  logic              soc,
  input  logic [DATA_W-1:0] din,
  output logic              clav,
  output logic              clav_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_first
);
  localparam int OFF_W  = $clog2(CELL_BYTES);
  localparam int SLOT_W = (CELL_SLOTS > 1) ? $clog2(CELL_SLOTS) : 1;
  localparam int CNT_W  = $clog2(CELL_SLOTS + 1);

  logic             wr_strobe, commit, busy, busy_nxt;
  logic [OFF_W-1:0] wr_off;
  logic [CNT_W-1:0] stored, stored_nxt;

  cell_rx_framer #(.CELL_BYTES(CELL_BYTES), .OFF_W(OFF_W)) u_framer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .soc(soc), .port_en(port_en),
    .space_ok(stored < CNT_W'(CELL_SLOTS)),
    .wr_strobe(wr_strobe), .wr_off(wr_off), .commit(commit),
    .busy(busy), .busy_nxt(busy_nxt)
  );

  cell_rx_store #(
    .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .CELL_SLOTS(CELL_SLOTS),
    .OFF_W(OFF_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_off(wr_off), .din(din),
    .commit(commit), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_first(rd_first),
    .stored(stored), .stored_nxt(stored_nxt)
  );

  cell_rx_clav #(
    .CELL_SLOTS(CELL_SLOTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
  ) u_clav (
    .clk(clk), .rst(rst), .mphy_mode(mphy_mode), .poll_addr(poll_addr),
    .stored_nxt(stored_nxt), .busy_nxt(busy_nxt),
    .clav(clav), .clav_oe(clav_oe)
  );

  // R3
  room_full_chk: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, stored} + (CNT_W + 1)'(busy)) >= (CNT_W + 1)'(CELL_SLOTS)) |-> !clav);
endmodule

// File: tb/cell_rx_port_bench.sv
module cell_rx_port_bench;
  localparam int CB = 53;
  localparam int PA = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_en = 1'b1, mphy_mode = 1'b0, wr_en = 1'b0, soc = 1'b0;
  logic [4:0] poll_addr = 5'd0;
  logic [7:0] din = 8'h00;
  logic       clav, clav_oe, rd_valid, rd_first;
  logic [7:0] rd_data;
  logic       rd_go = 1'b0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;

  cell_rx_port #(.PORT_ADDR(PA)) u_cell_rx_port (
    .clk(clk), .rst(rst), .port_en(port_en), .mphy_mode(mphy_mode),
    .poll_addr(poll_addr), .wr_en(wr_en), .soc(soc), .din(din),
    .clav(clav), .clav_oe(clav_oe), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_go), .rd_first(rd_first)
  );

  function automatic logic [7:0] bval(int id, int o);
    return 8'((id * 37 + o * 3) & 255);
  endfunction

  task automatic check(bit ok, string msg, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid && rd_go) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected output byte", int'(rd_data), -1);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({rd_first, rd_data} == e, "R4/R1 byte or first flag", int'({rd_first, rd_data}), int'(e));
      end
    end
  end

  task automatic put_byte(input logic s, input logic [7:0] d);
    @(posedge clk); #1;
    soc = s; din = d; wr_en = 1'b1;
  endtask

  task automatic stop_wr();
    @(posedge clk); #1;
    wr_en = 1'b0; soc = 1'b0; din = 8'hEE;
  endtask

  task automatic send_run(int id, int from, int upto, int pause_at);
    for (int o = from; o < upto; o++) begin
      if (o == pause_at) begin
        @(posedge clk); #1;
        wr_en = 1'b0; soc = 1'b0; din = 8'hEE;
      end
      put_byte(o == 0, bval(id, o));
    end
    stop_wr();
  endtask

  task automatic expect_cell(int id);
    for (int o = 0; o < CB; o++) exp_q.push_back({(o == 0), bval(id, o)});
  endtask

  task automatic send_cell(int id, bit keep, int pause_at);
    if (keep) expect_cell(id);
    send_run(id, 0, CB, pause_at);
  endtask

  task automatic read_n(int n);
    @(posedge clk); #1 rd_go = 1'b1;
    repeat (n) @(posedge clk);
    #1 rd_go = 1'b0;
  endtask

  task automatic drain(string tag);
    int t = 0;
    @(posedge clk); #1 rd_go = 1'b1;
    while (exp_q.size() != 0 && t < 5000) begin
      @(posedge clk); t++;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, {tag, " expected bytes left"}, exp_q.size(), 0);
    check(rd_valid == 1'b0, {tag, " rd_valid after drain"}, rd_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_valid == 0, "R10 rd_valid in reset", rd_valid, 0);
    check(clav == 0, "R10 clav in reset", clav, 0);
    check(clav_oe == 0, "R10 clav_oe in reset", clav_oe, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(clav_oe == 1, "R7 clav_oe non-addressed mode", clav_oe, 1);
    check(clav == 1, "R3 clav empty store", clav, 1);

    // R8: stray bytes while idle
    send_run(4, 1, 6, -1);
    @(negedge clk);
    check(rd_valid == 0, "R8 stray bytes stored", rd_valid, 0);

    // R1: cell with pause in the middle
    rd_go = 1'b1;
    send_cell(1, 1, 25);
    drain("R1");

    // R6: short cell then full cell
    send_run(2, 0, 20, -1);
    send_cell(3, 1, -1);
    // back-to-back truncation without a gap
    for (int o = 0; o < 10; o++) put_byte(o == 0, bval(5, o));
    send_cell(15, 1, -1);
    drain("R6");

    // R2/R3/R4: fill the store
    rd_go = 1'b0;
    send_cell(10, 1, -1);
    send_cell(11, 1, -1);
    send_cell(12, 1, -1);
    @(negedge clk);
    check(clav == 1, "R3 clav with three cells", clav, 1);
    expect_cell(13);
    put_byte(1'b1, bval(13, 0));
    stop_wr();
    @(negedge clk);
    check(clav == 0, "R3 clav after first byte of last slot", clav, 0);
    send_run(13, 1, CB, -1);
    send_cell(14, 0, -1);
    @(negedge clk);
    check(clav == 0, "R2 clav when full", clav, 0);
    check(rd_valid == 1, "R2 rd_valid when full", rd_valid, 1);
    read_n(CB - 1);
    @(negedge clk);
    check(clav == 0, "R4 slot held before last byte read", clav, 0);
    read_n(1);
    @(negedge clk);
    check(clav == 1, "R4 slot freed after last byte read", clav, 1);
    drain("R2");

    // R5: disable in mid-cell
    expect_cell(6);
    send_run(6, 0, 10, -1);
    port_en = 1'b0;
    send_run(6, 10, CB, -1);
    send_cell(7, 0, -1);
    drain("R5");

    // R9: re-enable, stray bytes, then a real cell
    port_en = 1'b1;
    send_run(9, 5, 15, -1);
    send_cell(8, 1, -1);
    drain("R9");

    // R7: addressed mode
    @(posedge clk); #1 mphy_mode = 1'b1; poll_addr = 5'd5;
    @(posedge clk); @(negedge clk);
    check(clav_oe == 0, "R7 clav_oe other address", clav_oe, 0);
    check(clav == 0, "R7 clav gated", clav, 0);
    @(posedge clk); #1 poll_addr = 5'(PA);
    @(posedge clk); @(negedge clk);
    check(clav_oe == 1, "R7 clav_oe own address", clav_oe, 1);
    check(clav == 1, "R7 clav own address", clav, 1);
    @(posedge clk); #1 poll_addr = 5'd5;
    @(posedge clk); @(negedge clk);
    check(clav_oe == 0, "R7 clav_oe released", clav_oe, 0);

    finish_run();
  end
endmodule